// File: doc/BRIEF.md
# Vectored Interrupt Acceptor with Return-Address Stack

This block sits beside a small sequential processor core. It watches one active-low external interrupt line and decides when the core should be sent to a fixed service address. It also keeps the shallow stack of return addresses that subroutine calls and returns use. The core drives an instruction-cycle strobe together with status for that cycle:

- whether an instruction retired;
- whether the retiring instruction is a jump, call, return or load-B-immediate ("chain" instruction);
- call (push) and return (pop) requests;
- its PC plus one;
- its interrupt-enable bit;
- its skip-pending flag.

A request is formed only from a falling edge that stays low for a programmable number of strobes. The request is latched until it is taken. Acceptance waits for an ordinary instruction to retire, so a run of back-to-back chain instructions is never split.

On acceptance the block raises a one-cycle vector indication that does three things: it loads the fixed vector address, tells the core to clear its enable bit, and pushes the return address. Every stack level also stores the skip-pending flag that was present when that level was pushed. A return hands the flag back together with the address, so a skip that was interrupted is completed after the service routine.

All outputs are combinational in the strobe cycle in which they apply. State changes only on clock edges where the strobe is high.

Top module: `irq_vector_stack`

## Requirements
- R1: After reset the request latch and all stack levels are clear. A line held low since reset produces no request. A return issued right after reset yields `pc_next` = 0 and `skip_restore` = 0.
- R2: A request is latched at the strobe that completes a sample pattern of one high followed by LOW_CYC (default 2) consecutive low samples. The line is sampled only on strobes. A low run shorter than LOW_CYC never produces a request.
- R3: A request is accepted only while `ien` is 1. While `ien` is 0, a latched request is held until it is accepted.
- R4: Acceptance requires a strobe with `ins_done`=1, `chain_op`=0, `push_req`=0 and `pop_req`=0. The request stays pending across retiring chain instructions, non-retiring cycles, calls and returns.
- R5: In the accepting strobe, `take_vec`, `ien_clr` and `pc_load` are 1 and `pc_next` equals VEC_ADDR (default 0x0FF). The request latch clears unless a new request qualifies in the same strobe.
- R6: Acceptance pushes `pc_inc` together with `skip_pend` onto the stack.
- R7: A push (`push_req` on a strobe) moves every level down by one and writes {`skip_pend`, `pc_inc`} on top. The entry in the deepest of the DEPTH (default 3) levels is discarded.
- R8: A return (`pop_req` on a strobe) sets `pc_load`=1, `pc_next` to the top address and `skip_restore` to the top saved skip flag. It moves every level up by one and clears the deepest level to zero.
- R9: When `push_req` and `pop_req` are both 1, only the return takes effect.
- R10: Without a strobe, no output is asserted and no input changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_stb | input | 1 | Instruction-cycle strobe |
| irq_n | input | 1 | External interrupt line, active low |
| ins_done | input | 1 | An instruction retires this cycle |
| chain_op | input | 1 | Retiring instruction is a control transfer or load-B-immediate |
| push_req | input | 1 | Call: push return address |
| pop_req | input | 1 | Return: pop stack into PC |
| ien | input | 1 | Core interrupt-enable bit |
| pc_inc | input | AW | Address of the next sequential instruction |
| skip_pend | input | 1 | Core has a skip pending |
| take_vec | output | 1 | Interrupt accepted this strobe |
| ien_clr | output | 1 | Clear the core enable bit |
| pc_load | output | 1 | `pc_next` must be loaded into the PC |
| pc_next | output | AW | Vector or return address, 0 when `pc_load` is 0 |
| skip_restore | output | 1 | Saved skip flag returned with a pop |

## Verification
The bench sweeps low-pulse lengths from zero to beyond the threshold, with the enable both set and clear. This exposes a qualifier that counts one strobe too few, one that fires on a level instead of an edge, and a latch that drops a request arriving while disabled.

Directed sequences hold a pending request through chain instructions, non-retiring cycles, calls and returns. A design that vectors inside a jump chain would show `take_vec` early and push the wrong return address.

Overfilling the stack and then draining it shows the oldest entry being discarded and zeros coming back. It also catches skip flags that travel with the wrong level. A design that ignores the strobe, or lets a push win over a simultaneous pop, returns a stale or doubled address.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
   localparam int unsigned IRQV_AW_DEF    = 11;
   localparam int unsigned IRQV_DEPTH_DEF = 3;
   localparam int unsigned IRQV_LOW_DEF   = 2;

   typedef enum logic [1:0] {
      STK_HOLD = 2'd0,
      STK_PUSH = 2'd1,
      STK_POP  = 2'd2
   } stk_op_e;
endpackage

// File: rtl/irqv_qual.sv
module irqv_qual #(
   parameter int unsigned LOW_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic line_n,
   output logic qual
);
   generate
      if (LOW_CYC <= 8) begin : g_shift
         localparam int unsigned HW = LOW_CYC + 1;
         localparam logic [HW-1:0] PATTERN = {1'b1, {LOW_CYC{1'b0}}};
         logic [HW-1:0] hist_q;
         logic [HW-1:0] hist_nxt;

         assign hist_nxt = {hist_q[HW-2:0], line_n};
         assign qual     = stb && (hist_nxt == PATTERN);

         always_ff @(posedge clk) begin
            if (!rst_n)   hist_q <= '0;
            else if (stb) hist_q <= hist_nxt;
         end
      end else begin : g_count
         localparam int unsigned CW = $clog2(LOW_CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(LOW_CYC - 1);
         logic          armed_q;
         logic [CW-1:0] run_q;

         assign qual = stb && !line_n && armed_q && (run_q == LAST);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               armed_q <= 1'b0;
               run_q   <= '0;
            end else if (stb) begin
               if (line_n) begin
                  armed_q <= 1'b1;
                  run_q   <= '0;
               end else if (armed_q) begin
                  if (run_q == LAST) armed_q <= 1'b0;
                  run_q <= run_q + 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/irqv_accept.sv
module irqv_accept (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic done,
   input  logic chain,
   input  logic push,
   input  logic pop,
   input  logic en,
   input  logic qual,
   output logic acc,
   output logic req_q
);
   logic boundary;

   assign boundary = stb && done && !chain && !push && !pop;
   assign acc      = boundary && en && req_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   req_q <= 1'b0;
      else if (stb) req_q <= qual | (req_q & ~acc);
   end
endmodule

// File: rtl/irqv_stack.sv
module irqv_stack
   import irqv_pkg::*;
#(
   parameter int unsigned AW    = 11,
   parameter int unsigned DEPTH = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  stk_op_e       op,
   input  logic [AW-1:0] wr_addr,
   input  logic          wr_skip,
   output logic [AW-1:0] top_addr,
   output logic          top_skip
);
   logic [DEPTH-1:0][AW-1:0] addr_q;
   logic [DEPTH-1:0]         skip_q;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
         logic [AW-1:0] push_a, pop_a;
         logic          push_s, pop_s;

         if (i == 0) begin : g_top
            assign push_a = wr_addr;
            assign push_s = wr_skip;
         end else begin : g_mid
            assign push_a = addr_q[i-1];
            assign push_s = skip_q[i-1];
         end

         if (i == DEPTH - 1) begin : g_bot
            assign pop_a = '0;
            assign pop_s = 1'b0;
         end else begin : g_up
            assign pop_a = addr_q[i+1];
            assign pop_s = skip_q[i+1];
         end

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               addr_q[i] <= '0;
               skip_q[i] <= 1'b0;
            end else begin
               case (op)
                  STK_PUSH: begin
                     addr_q[i] <= push_a;
                     skip_q[i] <= push_s;
                  end
                  STK_POP: begin
                     addr_q[i] <= pop_a;
                     skip_q[i] <= pop_s;
                  end
                  default: ;
               endcase
            end
         end
      end
   endgenerate

   assign top_addr = addr_q[0];
   assign top_skip = skip_q[0];
endmodule

// File: rtl/irq_vector_stack.sv
module irq_vector_stack
   import irqv_pkg::*;
#(
   parameter int unsigned   AW       = IRQV_AW_DEF,
   parameter int unsigned   DEPTH    = IRQV_DEPTH_DEF,
   parameter int unsigned   LOW_CYC  = IRQV_LOW_DEF,
   parameter logic [AW-1:0] VEC_ADDR = AW'(8'hFF)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cyc_stb,
   input  logic          irq_n,
   input  logic          ins_done,
   input  logic          chain_op,
   input  logic          push_req,
   input  logic          pop_req,
   input  logic          ien,
   input  logic [AW-1:0] pc_inc,
   input  logic          skip_pend,
   output logic          take_vec,
   output logic          ien_clr,
   output logic          pc_load,
   output logic [AW-1:0] pc_next,
   output logic          skip_restore
);
   generate
      if (AW < 2)      begin : g_bad_aw    $error("AW must be at least 2");      end
      if (DEPTH < 1)   begin : g_bad_depth $error("DEPTH must be at least 1");   end
      if (LOW_CYC < 1) begin : g_bad_low   $error("LOW_CYC must be at least 1"); end
   endgenerate

   logic          qual;
   logic          acc;
   logic          req_q;
   logic          pop_go;
   logic          push_go;
   stk_op_e       op;
   logic [AW-1:0] top_addr;
   logic          top_skip;

   irqv_qual #(.LOW_CYC(LOW_CYC)) u_qual (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (cyc_stb),
      .line_n (irq_n),
      .qual   (qual)
   );

   irqv_accept u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .stb   (cyc_stb),
      .done  (ins_done),
      .chain (chain_op),
      .push  (push_req),
      .pop   (pop_req),
      .en    (ien),
      .qual  (qual),
      .acc   (acc),
      .req_q (req_q)
   );

   assign pop_go  = cyc_stb && pop_req;
   assign push_go = cyc_stb && push_req && !pop_req;

   always_comb begin
      if (pop_go)                op = STK_POP;
      else if (push_go || acc)   op = STK_PUSH;
      else                       op = STK_HOLD;
   end

   irqv_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .wr_addr  (pc_inc),
      .wr_skip  (skip_pend),
      .top_addr (top_addr),
      .top_skip (top_skip)
   );

   assign take_vec     = acc;
   assign ien_clr      = acc;
   assign pc_load      = acc || pop_go;
   assign pc_next      = acc ? VEC_ADDR : (pop_go ? top_addr : '0);
   assign skip_restore = pop_go && top_skip;
endmodule

// File: rtl/irqv_chk.sv
module irqv_chk #(
   parameter int unsigned   AW       = 11,
   parameter logic [AW-1:0] VEC_ADDR = '1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cyc_stb,
   input logic          irq_n,
   input logic          pop_req,
   input logic          ien,
   input logic [AW-1:0] pc_inc,
   input logic          skip_pend,
   input logic          take_vec,
   input logic          ien_clr,
   input logic          pc_load,
   input logic [AW-1:0] pc_next,
   input logic          skip_restore,
   input logic          req_q,
   input logic [AW-1:0] top_addr,
   input logic          top_skip
);
   a_r2_req_after_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> $past(!irq_n && cyc_stb));

   a_r3_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      take_vec |-> (ien && req_q));

   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (req_q && !take_vec) |=> req_q);

   a_r5_vector_out: assert property (@(posedge clk) disable iff (!rst_n)
      take_vec |-> (pc_load && ien_clr && pc_next == VEC_ADDR));

   a_r6_push_saved: assert property (@(posedge clk) disable iff (!rst_n)
      take_vec |=> (top_addr == $past(pc_inc) && top_skip == $past(skip_pend)));

   a_r8_pop_out: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_stb && pop_req) |-> (pc_load && pc_next == top_addr && skip_restore == top_skip));

   a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_stb |-> (!pc_load && !take_vec && !ien_clr && !skip_restore));
endmodule

bind irq_vector_stack irqv_chk #(.AW(AW), .VEC_ADDR(VEC_ADDR)) u_chk (.*);

// File: tb/tb_irq_vector_stack.sv
module tb_irq_vector_stack;
   localparam int AW  = 11;
   localparam int DEP = 3;
   localparam int LOW = 2;
   localparam logic [AW-1:0] VEC = 11'h0FF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_stb = 0, irq_n = 0, ins_done = 0, chain_op = 0;
   logic push_req = 0, pop_req = 0, ien = 0, skip_pend = 0;
   logic [AW-1:0] pc_inc = '0;
   logic take_vec, ien_clr, pc_load, skip_restore;
   logic [AW-1:0] pc_next;

   int checks = 0;
   int fails  = 0;

   // reference state built from the requirements
   logic          m_seen;
   int            m_run;
   logic          m_req;
   logic [AW-1:0] m_addr [DEP];
   logic          m_skip [DEP];

   always #2 clk = ~clk;

   irq_vector_stack dut (
      .clk(clk), .rst_n(rst_n), .cyc_stb(cyc_stb), .irq_n(irq_n),
      .ins_done(ins_done), .chain_op(chain_op), .push_req(push_req),
      .pop_req(pop_req), .ien(ien), .pc_inc(pc_inc), .skip_pend(skip_pend),
      .take_vec(take_vec), .ien_clr(ien_clr), .pc_load(pc_load),
      .pc_next(pc_next), .skip_restore(skip_restore)
   );

   task automatic chk(input string tag, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, got, exp, $time);
      end
   endtask

   task automatic step(input string tag, input logic s, input logic irq, input logic dn,
                       input logic ch, input logic pu, input logic po, input logic en,
                       input logic [AW-1:0] pci, input logic sk);
      logic e_acc, e_pop, qual;
      logic [AW-1:0] e_next;
      cyc_stb = s; irq_n = irq; ins_done = dn; chain_op = ch;
      push_req = pu; pop_req = po; ien = en; pc_inc = pci; skip_pend = sk;
      #1;
      e_acc  = s && dn && !ch && !pu && !po && en && m_req;
      e_pop  = s && po;
      e_next = e_acc ? VEC : (e_pop ? m_addr[0] : '0);
      chk(tag, "take_vec", int'(take_vec), int'(e_acc));
      chk(tag, "ien_clr", int'(ien_clr), int'(e_acc));
      chk(tag, "pc_load", int'(pc_load), int'(e_acc || e_pop));
      chk(tag, "pc_next", int'(pc_next), int'(e_next));
      chk(tag, "skip_restore", int'(skip_restore), int'(e_pop && m_skip[0]));
      qual = 1'b0;
      if (s) begin
         if (irq) begin
            m_seen = 1'b1; m_run = 0;
         end else if (m_seen) begin
            m_run++;
            if (m_run == LOW) begin qual = 1'b1; m_seen = 1'b0; end
         end
         m_req = qual || (m_req && !e_acc);
         if (e_pop) begin
            for (int i = 0; i < DEP - 1; i++) begin
               m_addr[i] = m_addr[i+1]; m_skip[i] = m_skip[i+1];
            end
            m_addr[DEP-1] = '0; m_skip[DEP-1] = 1'b0;
         end else if (pu || e_acc) begin
            for (int i = DEP - 1; i > 0; i--) begin
               m_addr[i] = m_addr[i-1]; m_skip[i] = m_skip[i-1];
            end
            m_addr[0] = pci; m_skip[0] = sk;
         end
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   // idle retiring cycles, line high
   task automatic run(input string tag, input int n, input logic en);
      for (int k = 0; k < n; k++) step(tag, 1, 1, 1, 0, 0, 0, en, 11'h010 + AW'(k), 0);
   endtask

   // 1 high, then len low strobes, line then returns high
   task automatic pulse(input string tag, input int len, input logic en);
      step(tag, 1, 1, 0, 0, 0, 0, en, 0, 0);
      for (int k = 0; k < len; k++) step(tag, 1, 0, 0, 0, 0, 0, en, 0, 0);
   endtask

   initial begin
      #(200000 * 4);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      m_seen = 0; m_run = 0; m_req = 0;
      for (int i = 0; i < DEP; i++) begin m_addr[i] = '0; m_skip[i] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: line low since reset never forms a request; empty stack pops zero
      for (int k = 0; k < 4; k++) step("R1", 1, 0, 1, 0, 0, 0, 1, 11'h001, 0);
      step("R1", 1, 1, 1, 0, 0, 1, 1, 11'h002, 0);

      // R2: one-strobe low pulse is ignored
      pulse("R2", 1, 1);
      run("R2", 4, 1);

      // R10: low only between strobes is ignored; push without strobe ignored
      step("R10", 1, 1, 0, 0, 0, 0, 1, 0, 0);
      for (int k = 0; k < 4; k++) step("R10", 0, 0, 1, 0, 0, 0, 1, 0, 0);
      run("R10", 3, 1);
      step("R10", 0, 1, 1, 0, 1, 0, 1, 11'h3AA, 1);
      step("R10", 1, 1, 1, 0, 0, 1, 1, 0, 0);

      // R2/R5/R6: qualifying pulse, accept carries skip flag, then return restores it
      pulse("R2", 2, 0);
      step("R5", 1, 1, 1, 0, 0, 0, 1, 11'h123, 1);
      run("R5", 2, 1);
      step("R6", 1, 1, 1, 0, 0, 1, 0, 0, 0);

      // R3: request held while disabled
      pulse("R3", 3, 0);
      run("R3", 5, 0);
      step("R3", 1, 1, 1, 0, 0, 0, 1, 11'h456, 0);
      step("R3", 1, 1, 1, 0, 0, 1, 1, 0, 0);

      // R4: pending request waits through non-retiring, chain, call and return cycles
      pulse("R4", 2, 1);
      step("R4", 1, 1, 0, 0, 0, 0, 1, 11'h050, 0);
      step("R4", 1, 1, 1, 1, 0, 0, 1, 11'h051, 0);
      step("R4", 1, 1, 1, 1, 0, 0, 1, 11'h052, 0);
      step("R4", 1, 1, 1, 0, 1, 0, 1, 11'h055, 1);
      step("R4", 1, 1, 1, 0, 0, 1, 1, 11'h056, 0);
      step("R4", 1, 1, 1, 0, 0, 0, 1, 11'h077, 0);
      step("R4", 1, 1, 1, 0, 0, 1, 1, 0, 0);

      // R7/R8: overfill then drain
      step("R7", 1, 1, 1, 1, 1, 0, 0, 11'h101, 1);
      step("R7", 1, 1, 1, 1, 1, 0, 0, 11'h202, 0);
      step("R7", 1, 1, 1, 1, 1, 0, 0, 11'h303, 1);
      step("R7", 1, 1, 1, 1, 1, 0, 0, 11'h404, 0);
      for (int k = 0; k < 4; k++) step("R8", 1, 1, 1, 1, 0, 1, 0, 0, 0);

      // R9: simultaneous push and pop acts as pop only
      step("R9", 1, 1, 1, 1, 1, 0, 0, 11'h511, 1);
      step("R9", 1, 1, 1, 1, 1, 0, 0, 11'h622, 0);
      step("R9", 1, 1, 1, 1, 1, 1, 0, 11'h7FF, 1);
      step("R9", 1, 1, 1, 1, 0, 1, 0, 0, 0);
      step("R9", 1, 1, 1, 1, 0, 1, 0, 0, 0);

      // R2/R3 sweep over pulse length and enable
      for (int len = 0; len <= 4; len++) begin
         for (int e = 0; e < 2; e++) begin
            pulse("R2", len, e[0]);
            run("R3", 3, e[0]);
            run("R3", 2, 1);
            step("R8", 1, 1, 1, 1, 0, 1, 0, 0, 0);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule